// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Controller

This block is the interrupt front end of a peripheral that has up to fifteen event sources. Each event pulse sets a sticky bit in a pending register. A host-written enable register chooses which pending bits may interrupt. The causes are split into two groups, a receive group and a transmit group. Each group has its own request line, acknowledge input and chain-enable pair. Within a group the lowest-numbered enabled pending cause wins.

During an acknowledge cycle, a group that holds the chain enable and has a live request claims the cycle. It places an 8-bit vector on the data bus and asserts the transfer acknowledge. The vector is built from a programmable 4-bit base and a 4-bit cause index, so every cause has a vector of its own. A group whose chain enable is inactive stays off the bus and keeps its chain output inactive. A group with nothing to report passes the enable on to the next device.

Once a cause has been acknowledged, its group is in service. That group's request stays withdrawn, even against a higher-priority arrival, until the host clears the serviced cause by writing a 1 to its pending bit.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset the pending, enable and base registers are zero, both request lines are high (inactive), `data_oe` and `dtack` are low, and each `eo_n` bit equals its `ei_n` bit.
- R2: A one-cycle pulse on `ev_in[i]` sets pending bit i at the next clock edge; the group request drops low only if enable bit i is set.
- R3: Causes 0 to 7 belong to group 0 (receive) and drive `irq_n[0]`; causes 8 to 14 belong to group 1 (transmit) and drive `irq_n[1]`.
- R4: Among enabled pending causes of a group, the lowest bit number wins, and its vector index is the bit number plus one (1 to 15; 0 is never sent).
- R5: With `iack_n[g]` and `ei_n[g]` both low and group g requesting, `data_oe` and `dtack` go high at the next edge and stay high until the edge after `iack_n[g]` returns high.
- R6: While `ei_n[g]` is high, an acknowledge on group g produces neither `data_oe` nor `dtack`, and `eo_n[g]` stays high.
- R7: `eo_n[g]` is low only when `ei_n[g]` is low, group g has no request and is not driving an acknowledge.
- R8: A write with `wr_sel`=0 clears every pending bit whose `wr_data` bit is 1 and leaves the others unchanged; an event in the same cycle wins over the clear.
- R9: After an acknowledge the group request stays high until the serviced cause's pending bit has been cleared; it may return one edge after the clearing edge.
- R10: A write with `wr_sel`=2 loads `wr_data[3:0]` as the base, which forms vector bits 7:4; `wr_sel`=1 loads the enable register from `wr_data[14:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | 15 | Event pulses, one per cause |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Write target: 0 clear pending, 1 enable, 2 base |
| wr_data | input | 15 | Host write data |
| irq_n | output | 2 | Request per group, active low |
| iack_n | input | 2 | Acknowledge per group, active low |
| ei_n | input | 2 | Chain enable in per group, active low |
| eo_n | output | 2 | Chain enable out per group, active low |
| dtack | output | 1 | Transfer acknowledge for a claimed cycle |
| data_oe | output | 1 | Vector drive enable |
| data_out | output | 8 | Vector: base in bits 7:4, cause index in bits 3:0 |

## Verification
The assertions assume that the host holds an acknowledge low until the block has answered it or for a bounded time, and never acknowledges a group while a chain enable toggles mid-cycle. They also assume that the two groups are not acknowledged in the same cycle. The stimulus keeps within these limits. It issues one acknowledge at a time, and it changes `ei_n` only while `iack_n` is high. Every event and write is a single-cycle pulse applied away from the clock edge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NCAUSE = 15;
    localparam int IDXW   = 4;
    localparam int BASEW  = 8 - IDXW;
    localparam int NGRP   = 2;

    typedef enum logic [1:0] {
        SEL_PEND_CLR = 2'd0,
        SEL_ENABLE   = 2'd1,
        SEL_BASE     = 2'd2
    } wr_sel_e;

    typedef struct packed {
        logic [BASEW-1:0] base;
        logic [IDXW-1:0]  idx;
    } vector_t;

    // lowest set bit wins; index = bit + 1, zero when nothing is set
    function automatic logic [IDXW-1:0] top_cause(input logic [NCAUSE-1:0] pend);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (pend[i]) r = IDXW'(i + 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] ev_in,
    input  logic              wr_en,
    input  wr_sel_e           wr_sel,
    input  logic [NCAUSE-1:0] wr_data,
    output logic [NCAUSE-1:0] pend_q,
    output logic [NCAUSE-1:0] en_q,
    output logic [BASEW-1:0]  base_q
);
    logic [NCAUSE-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (wr_en && wr_sel == SEL_PEND_CLR) clr_mask = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            base_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | ev_in;
            if (wr_en && wr_sel == SEL_ENABLE) en_q <= wr_data;
            if (wr_en && wr_sel == SEL_BASE)   base_q <= wr_data[BASEW-1:0];
        end
    end
endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] pend_en,
    input  logic [NCAUSE-1:0] pend_raw,
    input  logic              iack_n,
    input  logic              ei_n,
    output logic              irq_n,
    output logic              eo_n,
    output logic              acking,
    output logic [IDXW-1:0]   svc_idx
);
    logic            busy;
    logic            req;
    logic [IDXW-1:0] svc_pos;

    assign req     = (|pend_en) && !busy;
    assign svc_pos = svc_idx - 1'b1;
    assign irq_n   = !req;
    assign eo_n    = ei_n || req || acking;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            acking  <= 1'b0;
            svc_idx <= '0;
        end else if (!acking && !iack_n && !ei_n && req) begin
            acking  <= 1'b1;
            busy    <= 1'b1;
            svc_idx <= top_cause(pend_en);
        end else begin
            if (acking && iack_n) acking <= 1'b0;
            if (busy && !pend_raw[svc_pos]) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter logic [14:0] GRP1_CAUSES = 15'h7F00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [14:0] ev_in,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [14:0] wr_data,
    output logic [1:0]  irq_n,
    input  logic [1:0]  iack_n,
    input  logic [1:0]  ei_n,
    output logic [1:0]  eo_n,
    output logic        dtack,
    output logic        data_oe,
    output logic [7:0]  data_out
);
    logic [NCAUSE-1:0] pend_q, en_q;
    logic [BASEW-1:0]  base_q;
    logic [NGRP-1:0]   acking;
    logic [IDXW-1:0]   svc_idx [NGRP];
    vector_t           vec;

    irq_cause_regs u_regs (
        .clk(clk), .rst(rst), .ev_in(ev_in), .wr_en(wr_en),
        .wr_sel(wr_sel_e'(wr_sel)), .wr_data(wr_data),
        .pend_q(pend_q), .en_q(en_q), .base_q(base_q)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [NCAUSE-1:0] SEL = (g == 0) ? ~GRP1_CAUSES : GRP1_CAUSES;
        irq_chain_unit u_unit (
            .clk(clk), .rst(rst),
            .pend_en(pend_q & en_q & SEL),
            .pend_raw(pend_q & SEL),
            .iack_n(iack_n[g]), .ei_n(ei_n[g]),
            .irq_n(irq_n[g]), .eo_n(eo_n[g]),
            .acking(acking[g]), .svc_idx(svc_idx[g])
        );
    end

    always_comb begin
        vec.base = base_q;
        vec.idx  = acking[0] ? svc_idx[0] : svc_idx[1];
    end

    assign data_oe  = |acking;
    assign dtack    = |acking;
    assign data_out = data_oe ? vec : 8'h00;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] irq_n,
    input logic [1:0] iack_n,
    input logic [1:0] ei_n,
    input logic [1:0] eo_n,
    input logic       dtack,
    input logic       data_oe,
    input logic [7:0] data_out
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq_n == 2'b11 && !data_oe && !dtack));

    // R4
    index_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> data_out[3:0] != 4'd0);

    // R5
    claim_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dtack) |-> $past((!iack_n[0] && !ei_n[0]) || (!iack_n[1] && !ei_n[1])));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe && iack_n == 2'b11) |=> !data_oe);

    // R6
    blocked_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (ei_n == 2'b11) |-> eo_n == 2'b11);

    // R7
    pass_grp0_chk: assert property (@(posedge clk) disable iff (rst)
        !eo_n[0] |-> (irq_n[0] && !ei_n[0]));

    // R7
    pass_grp1_chk: assert property (@(posedge clk) disable iff (rst)
        !eo_n[1] |-> (irq_n[1] && !ei_n[1]));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (.*);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ev_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [14:0] wr_data = '0;
    logic [1:0]  irq_n, eo_n;
    logic [1:0]  iack_n = 2'b11;
    logic [1:0]  ei_n = 2'b00;
    logic        dtack, data_oe;
    logic [7:0]  data_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit prev_oe = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    irq_vec_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic event_pulse(input logic [14:0] bits);
        ev_in = bits;
        tick();
        ev_in = '0;
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [14:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected vector, then runs one acknowledge
    task automatic do_ack(input int g, input logic [7:0] expv, input string tag);
        exp_q.push_back(expv);
        iack_n[g] = 1'b0;
        tick();
        chk(dtack === 1'b1, tag, dtack, 1);
        tick();
        iack_n[g] = 1'b1;
        tick();
        chk(data_oe === 1'b0 && dtack === 1'b0, {tag, " release"}, data_oe, 0);
    endtask

    // monitor: compares each new vector with the scoreboard
    always @(negedge clk) begin
        if (!rst && data_oe && !prev_oe) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected vector actual=%0h expected=none", data_out);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (data_out !== e) begin
                    n_fail++;
                    $display("FAIL R4 vector actual=%0h expected=%0h", data_out, e);
                end
            end
        end
        prev_oe = data_oe;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(irq_n == 2'b11, "R1 irq_n", irq_n, 3);
        chk(!data_oe && !dtack, "R1 data_oe", data_oe, 0);
        chk(eo_n == ei_n, "R1 eo_n", eo_n, ei_n);

        // R2 masked cause does not request
        event_pulse(15'h0008);
        chk(irq_n[0] == 1'b1, "R2 masked", irq_n[0], 1);
        chk(eo_n[0] == 1'b0, "R7 pass with nothing enabled", eo_n[0], 0);

        // R10 enable all, R2 request, R3 grouping
        host_wr(2'd1, 15'h7FFF);
        chk(irq_n[0] == 1'b0, "R2 enabled", irq_n[0], 0);
        chk(irq_n[1] == 1'b1, "R3 group 1 idle", irq_n[1], 1);
        chk(eo_n[0] == 1'b1, "R7 hold chain", eo_n[0], 1);

        // R4 priority, R10 base
        host_wr(2'd2, 15'h000A);
        event_pulse(15'h0002);
        do_ack(0, 8'hA2, "R4 bit1 over bit3");

        // R9 in service blocks higher-priority arrival
        chk(irq_n[0] == 1'b1, "R9 in service", irq_n[0], 1);
        event_pulse(15'h0001);
        chk(irq_n[0] == 1'b1, "R9 held vs higher", irq_n[0], 1);
        host_wr(2'd0, 15'h0002);
        tick();
        chk(irq_n[0] == 1'b0, "R9 released", irq_n[0], 0);
        do_ack(0, 8'hA1, "R4 bit0");
        host_wr(2'd0, 15'h0001);
        tick();
        do_ack(0, 8'hA4, "R4 bit3");
        host_wr(2'd0, 15'h0008);
        tick();
        chk(irq_n[0] == 1'b1, "R8 group0 cleared", irq_n[0], 1);

        // R6 chain enable inactive
        event_pulse(15'h0200);
        chk(irq_n[1] == 1'b0, "R3 group 1 request", irq_n[1], 0);
        ei_n[1] = 1'b1;
        tick();
        iack_n[1] = 1'b0;
        tick(2);
        chk(!data_oe && !dtack, "R6 no vector", dtack, 0);
        chk(eo_n[1] == 1'b1, "R6 eo_n high", eo_n[1], 1);
        iack_n[1] = 1'b1;
        tick();
        ei_n[1] = 1'b0;
        tick();
        do_ack(1, 8'hAA, "R3 R4 bit9");
        host_wr(2'd0, 15'h0200);
        tick();
        chk(eo_n[1] == 1'b0, "R7 pass after service", eo_n[1], 0);

        // R8 event wins over clear; zero clear is no-op
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 15'h1000; ev_in = 15'h1000;
        tick();
        wr_en = 1'b0; ev_in = '0;
        chk(irq_n[1] == 1'b0, "R8 set wins", irq_n[1], 0);
        host_wr(2'd0, 15'h0000);
        chk(irq_n[1] == 1'b0, "R8 zero clear", irq_n[1], 0);
        host_wr(2'd0, 15'h1000);
        chk(irq_n[1] == 1'b1, "R8 cleared", irq_n[1], 1);

        // R10 new base
        host_wr(2'd2, 15'h0003);
        event_pulse(15'h4000);
        do_ack(1, 8'h3F, "R10 base 3 bit14");
        host_wr(2'd0, 15'h4000);
        tick(2);
        chk(exp_q.size() == 0, "R5 all vectors seen", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule